// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

A single-port synchronous memory where every access has the same fixed latency. A command is issued on one enabled clock edge, and its data moves across the shared data bus in the window that ends two enabled edges later. Reads and writes use the same spacing, so a controller can mix them on consecutive cycles in any order. The bus never needs an idle slot when its direction changes. The tri-state bus is split into an input port, an output port and a drive-enable port, which the surrounding pad logic merges.

Each word holds four 9-bit lanes, and a write can update any subset of them. A short burst engine can extend a loaded command. Each advance beat steps the low address bits in linear or interleaved order. A clock enable freezes the whole block. Three chip selects gate the start of new commands. An asynchronous output enable can release the bus at any time.

Top module: `zbt_sram`

## Requirements
- R1: A word is 36 bits in four 9-bit lanes. Lane k occupies bits 9k+8 down to 9k. A write changes only the lanes whose `byte_we[k]` is 1 in its command cycle. The other lanes keep their old contents.
- R2: A read is accepted at an enabled edge N when `advance`=0, `wr`=0 and all three selects are 1. Between enabled edges N+1 and N+2, `dq_out` carries the stored word and `dq_oe` follows `out_en`.
- R3: A write is accepted at edge N when `advance`=0, `wr`=1 and all three selects are 1. At enabled edge N+2 it stores `dq_in`. During that data window `dq_oe` stays 0.
- R4: Commands may follow each other on every enabled edge in any mix. A read issued one cycle after a write to the same address returns the newly written lanes.
- R5: An edge with `clk_en`=0 ignores every synchronous input. No register changes and no array write happens, so `dq_out` and the pending commands are held.
- R6: A load with any select at 0 starts no command and ends any burst. Its data window leaves `dq_oe` at 0, and commands issued earlier still complete.
- R7: With `advance`=1 after a selected load, each beat repeats the loaded direction at the next address. The top address bits stay fixed. Beat k sets the low two bits to base+k mod 4 when `burst_lin`=1, or to base XOR k when it is 0. Byte enables are taken per beat. With `advance`=1 and no burst active, nothing starts.
- R8: `out_en`=0 forces `dq_oe` to 0 combinationally at any time.
- R9: While `rst_n` is 0 and after its release, no command is pending, no burst is active and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en | input | 1 | Clock enable; 0 freezes the block |
| advance | input | 1 | 0 loads a new command, 1 steps the active burst |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c | input | 1 | Chip select, active high |
| wr | input | 1 | 1 write, 0 read (used at load) |
| addr | input | ADDR_W | Word address (used at load) |
| byte_we | input | LANES | Per-lane write enables |
| burst_lin | input | 1 | 1 linear, 0 interleaved burst order |
| out_en | input | 1 | Asynchronous output enable, active high |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The tight case is a read issued on the cycle right after a write to the same word. The read's array access and the write's commit then fall on the same edge, and the read must see the merged new lanes. The bench issues back-to-back write/read pairs with random lane masks, at matching and differing addresses, and mixes them with random stalls. A reference array commits each write before it looks up the read on that same edge, and the value from that lookup is what the driven bus data is compared against.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_kind_e;

endpackage

// File: rtl/zbt_burst_step.sv
// Address of a burst beat: upper bits fixed, low bits stepped by the beat count.
module zbt_burst_step #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  beat,
    input  logic              linear,
    output logic [ADDR_W-1:0] beat_addr
);
    logic [CNT_W-1:0] low;

    always_comb begin
        if (linear) low = base[CNT_W-1:0] + beat;
        else        low = base[CNT_W-1:0] ^ beat;
    end

    generate
        if (ADDR_W > CNT_W) begin : g_upper
            assign beat_addr = {base[ADDR_W-1:CNT_W], low};
        end else begin : g_flat
            assign beat_addr = low[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/zbt_lane_ram.sv
// One byte lane: write port and registered read port with same-edge forwarding.
module zbt_lane_ram #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (en && rd_en) begin
            if (wr_en && (wr_addr == rd_addr)) rd_d = wr_data;
            else                               rd_d = mem[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
        if (en && wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/zbt_lane_array.sv
// Word-wide storage built from independent lanes.
module zbt_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            zbt_lane_ram #(
                .ADDR_W (ADDR_W),
                .LANE_W (LANE_W)
            ) u_lane (
                .clk     (clk),
                .en      (en),
                .wr_en   (wr_en && wr_be[g]),
                .wr_addr (wr_addr),
                .wr_data (wr_data[g*LANE_W +: LANE_W]),
                .rd_en   (rd_en),
                .rd_addr (rd_addr),
                .rd_data (rd_data[g*LANE_W +: LANE_W])
            );
        end
    endgenerate
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int LANES     = 4,
    parameter int LANE_W    = 9,
    parameter int BURST_LEN = 4,
    localparam int DATA_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              advance,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_c,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  byte_we,
    input  logic              burst_lin,
    input  logic              out_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int CNT_W = $clog2(BURST_LEN);

    typedef struct packed {
        logic              vld;
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
    } op_t;

    typedef struct packed {
        logic              act;    // burst running
        op_kind_e          kind;   // burst direction
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        op_t               s1;     // accepted command
        op_t               s2;     // command in its data window
    } state_t;

    state_t            st_d, st_q;
    logic              sel_all;
    op_kind_e          kind_in;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] rd_word;

    assign sel_all = sel_a & sel_b & sel_c;
    assign kind_in = wr ? OP_WRITE : OP_READ;
    assign cnt_nxt = st_q.cnt + CNT_W'(1);

    zbt_burst_step #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_step (
        .base      (st_q.base),
        .beat      (cnt_nxt),
        .linear    (burst_lin),
        .beat_addr (step_addr)
    );

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            st_d.s2 = st_q.s1;
            if (!advance) begin
                if (sel_all) begin
                    st_d.act  = 1'b1;
                    st_d.kind = kind_in;
                    st_d.base = addr;
                    st_d.cnt  = '0;
                    st_d.s1   = '{vld: 1'b1, kind: kind_in, addr: addr, be: byte_we};
                end else begin
                    st_d.act    = 1'b0;
                    st_d.s1.vld = 1'b0;
                end
            end else if (st_q.act) begin
                st_d.cnt = cnt_nxt;
                st_d.s1  = '{vld: 1'b1, kind: st_q.kind, addr: step_addr, be: byte_we};
            end else begin
                st_d.s1.vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    zbt_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .en      (clk_en),
        .wr_en   (st_q.s2.vld && (st_q.s2.kind == OP_WRITE)),
        .wr_addr (st_q.s2.addr),
        .wr_be   (st_q.s2.be),
        .wr_data (dq_in),
        .rd_en   (st_q.s1.vld && (st_q.s1.kind == OP_READ)),
        .rd_addr (st_q.s1.addr),
        .rd_data (rd_word)
    );

    assign dq_out = rd_word;
    assign dq_oe  = st_q.s2.vld && (st_q.s2.kind == OP_READ) && out_en;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              advance,
    input logic              sel_a,
    input logic              sel_b,
    input logic              sel_c,
    input logic              wr,
    input logic              out_en,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);
    // R2
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !advance && sel_a && sel_b && sel_c && !wr) ##1 clk_en
        |=> (dq_oe == out_en));

    // R3
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !advance && sel_a && sel_b && sel_c && wr) ##1 clk_en
        |=> !dq_oe);

    // R6
    desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !advance && !(sel_a && sel_b && sel_c)) ##1 clk_en
        |=> !dq_oe);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(dq_out));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !dq_oe);
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .advance (advance),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .sel_c   (sel_c),
    .wr      (wr),
    .out_en  (out_en),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
);

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;
    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n, clk_en, advance, sel_a, sel_b, sel_c, wr, burst_lin, out_en;
    logic [AW-1:0] addr;
    logic [3:0]    byte_we;
    logic [DW-1:0] dq_in, dq_out;
    logic          dq_oe;

    always #2.5 clk = ~clk;

    zbt_sram u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .advance(advance),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .wr(wr), .addr(addr),
        .byte_we(byte_we), .burst_lin(burst_lin), .out_en(out_en),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // reference state
    logic [DW-1:0] ref_mem [64];
    bit            m1_vld, m1_wr, m2_vld, m2_wr;
    logic [AW-1:0] m1_addr, m2_addr;
    logic [3:0]    m1_be, m2_be;
    logic [DW-1:0] m1_data, m2_data;
    string         m1_tag, m2_tag;
    bit            b_act, b_wr;
    logic [AW-1:0] b_base;
    logic [1:0]    b_cnt;
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic [DW-1:0] cur_exp;
    string         cur_tag;
    bit            popped;
    string         phase_tag = "R9";
    bit            oe_rand = 0;
    int            vectors = 0, misses = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: advances on the same enabled edges as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1_vld = 0; m2_vld = 0; b_act = 0; b_cnt = 0; popped = 0;
        end else if (clk_en) begin
            logic [63:0]   rnd;
            logic [AW-1:0] a;
            if (m2_vld && m2_wr)
                for (int l = 0; l < 4; l++)
                    if (m2_be[l]) ref_mem[m2_addr][l*9 +: 9] = m2_data[l*9 +: 9];
            m2_vld = m1_vld; m2_wr = m1_wr; m2_addr = m1_addr; m2_be = m1_be;
            m2_data = m1_data; m2_tag = m1_tag;
            popped = 0;
            if (m1_vld && !m1_wr) begin
                exp_q.push_back(ref_mem[m1_addr]);
                tag_q.push_back(m1_tag);
            end
            rnd = {$urandom(), $urandom()};
            if (!advance) begin
                if (sel_a && sel_b && sel_c) begin
                    b_act = 1; b_wr = wr; b_base = addr; b_cnt = 0;
                    m1_vld = 1; m1_wr = wr; m1_addr = addr; m1_be = byte_we;
                    m1_data = rnd[DW-1:0]; m1_tag = phase_tag;
                end else begin
                    b_act = 0; m1_vld = 0;
                end
            end else if (b_act) begin
                b_cnt = b_cnt + 2'd1;
                a = b_base;
                a[1:0] = burst_lin ? (b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt);
                m1_vld = 1; m1_wr = b_wr; m1_addr = a; m1_be = byte_we;
                m1_data = rnd[DW-1:0]; m1_tag = phase_tag;
            end else begin
                m1_vld = 0;
            end
        end
    end

    // monitor and bus-side write data driver
    always @(negedge clk) begin
        #1;
        if (m2_vld && m2_wr) dq_in = m2_data;
        else                 dq_in = {$urandom(), 4'h5};
        if (rst_n) begin
            if (m2_vld && !m2_wr) begin
                if (!popped) begin
                    cur_exp = exp_q.pop_front();
                    cur_tag = tag_q.pop_front();
                    popped  = 1;
                end
                if (out_en) begin
                    chk(dq_oe === 1'b1, {cur_tag, " read drive"}, {35'd0, dq_oe}, 1);
                    chk(dq_out === cur_exp, {cur_tag, " read data"}, dq_out, cur_exp);
                end else begin
                    chk(dq_oe === 1'b0, "R8 forced release", {35'd0, dq_oe}, 0);
                end
            end else begin
                chk(dq_oe === 1'b0, (m2_vld ? "R3 write window" : phase_tag),
                    {35'd0, dq_oe}, 0);
            end
        end
    end

    task automatic cyc(input bit ce, input bit adv, input bit [2:0] sel, input bit w,
                       input logic [AW-1:0] a, input logic [3:0] be);
        @(negedge clk);
        clk_en = ce; advance = adv; {sel_a, sel_b, sel_c} = sel;
        wr = w; addr = a; byte_we = be;
        if (oe_rand) out_en = ($urandom % 4) != 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 3'b000, 0, '0, '0);
    endtask

    task automatic rnd_op(input int stall_pct, input int desel_pct);
        bit ce  = ($urandom % 100) >= stall_pct;
        bit ds  = ($urandom % 100) < desel_pct;
        bit adv = ($urandom % 5) == 0;
        cyc(ce, adv, ds ? 3'($urandom % 7) : 3'b111, $urandom % 2, AW'($urandom), 4'($urandom));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; misses++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst_n = 0; clk_en = 1; advance = 0; {sel_a, sel_b, sel_c} = 3'b000;
        wr = 0; addr = '0; byte_we = '0; burst_lin = 1; out_en = 1; dq_in = '0;
        repeat (3) @(negedge clk);
        #1 chk(dq_oe === 1'b0, "R9 in reset", {35'd0, dq_oe}, 0);
        rst_n = 1;
        phase_tag = "R9";
        idle(3);

        // fill every word, full lanes
        phase_tag = "R3";
        for (int i = 0; i < 64; i++) cyc(1, 0, 3'b111, 1, AW'(i), 4'hF);
        idle(3);

        // back-to-back write then read of the same word, partial lanes
        phase_tag = "R4";
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] a = AW'($urandom);
            cyc(1, 0, 3'b111, 1, a, 4'($urandom));
            cyc(1, 0, 3'b111, 0, a, 4'($urandom));
            if (i % 3 == 0) cyc(1, 0, 3'b111, 1, AW'($urandom), 4'hF);
        end
        idle(3);

        // lane masks, read back later
        phase_tag = "R1";
        for (int i = 0; i < 16; i++) cyc(1, 0, 3'b111, 1, AW'(i), 4'(1 << (i % 4)));
        for (int i = 0; i < 16; i++) cyc(1, 0, 3'b111, 0, AW'(i), 4'($urandom));
        idle(3);

        // bursts in both orders, advance without burst does nothing
        phase_tag = "R7";
        for (int o = 0; o < 2; o++) begin
            burst_lin = (o == 0);
            for (int i = 0; i < 6; i++) begin
                logic [AW-1:0] a = AW'($urandom);
                cyc(1, 0, 3'b111, 1, a, 4'($urandom));
                for (int k = 0; k < 3; k++) cyc(1, 1, 3'b000, 0, '0, 4'($urandom));
                cyc(1, 0, 3'b111, 0, a, 4'h0);
                for (int k = 0; k < 5; k++) cyc(1, 1, 3'b000, 1, '0, 4'hF);
                idle(1);
                cyc(1, 1, 3'b111, 0, a, 4'hF);
                cyc(1, 1, 3'b111, 0, a, 4'hF);
            end
            idle(3);
        end

        // stalls
        phase_tag = "R5";
        for (int i = 0; i < 400; i++) rnd_op(40, 0);
        idle(3);

        // deselects
        phase_tag = "R6";
        for (int i = 0; i < 400; i++) rnd_op(0, 35);
        idle(3);

        // output enable toggling
        phase_tag = "R8";
        oe_rand = 1;
        for (int i = 0; i < 400; i++) rnd_op(10, 10);
        oe_rand = 0; out_en = 1;
        idle(3);

        // general mix
        phase_tag = "R2";
        for (int i = 0; i < 2000; i++) begin
            burst_lin = (i / 200) % 2;
            rnd_op(15, 15);
        end
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule